// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed memory and serves atomic requests from several requesters. Each requester has its own valid/ready request channel. One shared response channel carries the result and the index of the requester it belongs to. Three operations are available:

- compare-and-swap on one word;
- fetch-and-add on one word;
- compare-and-swap on an aligned pair of adjacent words, treated as one value twice the word width.

Each operation reads the location and then writes it conditionally. No other request can reach the memory between that read and that write. Every response returns the contents the location held before the operation.

Requests are served strictly one at a time. A round-robin arbiter picks among requesters that are valid in the same cycle. The granted request is captured, then executed in a single cycle against the memory, and then held on the response channel until the consumer takes it. Only after that is a new request accepted.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Opcode 0 (single compare-and-swap) with the addressed word equal to the low word of the compare field writes the low word of the data field into that word and responds with success=1, error=0 and the prior word in the low half of the old value (upper half zero).
- R2: Opcode 0 with a mismatch leaves memory unchanged and responds with success=0, error=0 and the prior word as old value.
- R3: Opcode 1 (fetch-and-add) writes the word plus the low word of the data field, wrapping modulo 2^WORD_W, and returns the prior word with success=0, error=0.
- R4: Opcode 2 (double compare-and-swap) at an even address treats the word at that address as the low half and the next word as the high half. It compares both against the full compare field, replaces both with the full data field only on a full match, and returns the prior pair as old value, with success set only when it wrote.
- R5: Opcode 2 at an odd address responds with error=1, success=0 and old value zero, and changes no memory word.
- R6: Opcode 3 is reserved: it responds with error=1, success=0 and old value zero, and changes no memory word.
- R7: From the cycle a request is accepted until its response handshake completes, every request ready is low; at most one request ready is ever high.
- R8: Among valid requesters the grant goes to the first one after the most recently granted one, in cyclic index order. After reset, requester 0 has top priority.
- R9: Each accepted request produces exactly one response tagged with its requester index. While the response is valid and not taken, the response stays valid and its fields do not change.
- R10: After reset every memory word reads zero and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Per-requester request valid |
| req_ready | output | NUM_REQ | Per-requester request ready |
| req_op | input | 2*NUM_REQ | Opcode per requester (0 CAS, 1 add, 2 double CAS, 3 reserved) |
| req_addr | input | AW*NUM_REQ | Word address per requester |
| req_cmp | input | 2*WORD_W*NUM_REQ | Compare value per requester (low word for single ops) |
| req_data | input | 2*WORD_W*NUM_REQ | Swap value or addend per requester (low word for single ops) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_id | output | IW | Index of the requester served |
| rsp_old | output | 2*WORD_W | Prior memory contents |
| rsp_success | output | 1 | Compare-and-swap wrote |
| rsp_error | output | 1 | Misaligned or reserved request |

## Verification
The hardest case to reach is a contested grant in which the round-robin pointer decides the outcome. It needs both requesters valid in the very cycle the unit returns to idle, and the winner depends on which requester was served last, including uncontested grants. The bench holds both valid lines high across several back-to-back transactions and predicts each winner from its own record of the last grantee. Response back-pressure runs with a repeating stall pattern, so that held responses and the ready-low window are both exercised under contention.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  typedef enum logic [1:0] {
    OP_CAS  = 2'd0,
    OP_FAA  = 2'd1,
    OP_DCAS = 2'd2,
    OP_RSVD = 2'd3
  } atom_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_RESP = 2'd2
  } atom_state_e;
endpackage

// File: rtl/atomic_rr_arbiter.sv
module atomic_rr_arbiter #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          any
);
  logic [IW-1:0] last_q;

  always_comb begin
    int cand;
    grant     = '0;
    grant_idx = '0;
    any       = 1'b0;
    for (int k = 1; k <= N; k++) begin
      cand = (int'(last_q) + k) % N;
      if (!any && req[cand]) begin
        any         = 1'b1;
        grant_idx   = IW'(cand);
        grant[cand] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IW'(N - 1);
    else if (advance) last_q <= grant_idx;
  end
endmodule

// File: rtl/atomic_word_store.sv
module atomic_word_store #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_lo,
  input  logic [AW-1:0]     addr_hi,
  output logic [WORD_W-1:0] rd_lo,
  output logic [WORD_W-1:0] rd_hi,
  input  logic              we_lo,
  input  logic [WORD_W-1:0] wd_lo,
  input  logic              we_hi,
  input  logic [WORD_W-1:0] wd_hi
);
  logic [WORD_W-1:0] mem [DEPTH];

  assign rd_lo = mem[addr_lo];
  assign rd_hi = mem[addr_hi];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)                               mem[i] <= '0;
      else if (we_lo && addr_lo == AW'(i))      mem[i] <= wd_lo;
      else if (we_hi && addr_hi == AW'(i))      mem[i] <= wd_hi;
    end
  end
endmodule

// File: rtl/atomic_exec_core.sv
module atomic_exec_core
  import atomic_rmw_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int AW     = 4
) (
  input  atom_op_e            op,
  input  logic [AW-1:0]       addr,
  input  logic [2*WORD_W-1:0] cmp,
  input  logic [2*WORD_W-1:0] data,
  input  logic [WORD_W-1:0]   cur_lo,
  input  logic [WORD_W-1:0]   cur_hi,
  output logic                we_lo,
  output logic                we_hi,
  output logic [WORD_W-1:0]   wd_lo,
  output logic [WORD_W-1:0]   wd_hi,
  output logic [2*WORD_W-1:0] old,
  output logic                success,
  output logic                error
);
  function automatic logic [WORD_W-1:0] wrap_add(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic words_match(input logic [2*WORD_W-1:0] a,
                                       input logic [2*WORD_W-1:0] b,
                                       input logic wide);
    return wide ? (a == b) : (a[WORD_W-1:0] == b[WORD_W-1:0]);
  endfunction

  logic [2*WORD_W-1:0] cur_pair;
  assign cur_pair = {cur_hi, cur_lo};

  always_comb begin
    we_lo   = 1'b0;
    we_hi   = 1'b0;
    wd_lo   = data[WORD_W-1:0];
    wd_hi   = data[2*WORD_W-1:WORD_W];
    old     = '0;
    success = 1'b0;
    error   = 1'b0;
    unique case (op)
      OP_CAS: begin
        old = {{WORD_W{1'b0}}, cur_lo};
        if (words_match(cur_pair, cmp, 1'b0)) begin
          we_lo   = 1'b1;
          success = 1'b1;
        end
      end
      OP_FAA: begin
        old   = {{WORD_W{1'b0}}, cur_lo};
        wd_lo = wrap_add(cur_lo, data[WORD_W-1:0]);
        we_lo = 1'b1;
      end
      OP_DCAS: begin
        if (addr[0]) begin
          error = 1'b1;
        end else begin
          old = cur_pair;
          if (words_match(cur_pair, cmp, 1'b1)) begin
            we_lo   = 1'b1;
            we_hi   = 1'b1;
            success = 1'b1;
          end
        end
      end
      default: error = 1'b1;
    endcase
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int DEPTH   = 16,
  parameter int NUM_REQ = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_REQ-1:0]            req_valid,
  output logic [NUM_REQ-1:0]            req_ready,
  input  logic [2*NUM_REQ-1:0]          req_op,
  input  logic [AW*NUM_REQ-1:0]         req_addr,
  input  logic [2*WORD_W*NUM_REQ-1:0]   req_cmp,
  input  logic [2*WORD_W*NUM_REQ-1:0]   req_data,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [IW-1:0]                 rsp_id,
  output logic [2*WORD_W-1:0]           rsp_old,
  output logic                          rsp_success,
  output logic                          rsp_error
);
  localparam int DW = 2 * WORD_W;

  logic [1:0]    op_a   [NUM_REQ];
  logic [AW-1:0] addr_a [NUM_REQ];
  logic [DW-1:0] cmp_a  [NUM_REQ];
  logic [DW-1:0] data_a [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slice
    assign op_a[g]   = req_op[g*2 +: 2];
    assign addr_a[g] = req_addr[g*AW +: AW];
    assign cmp_a[g]  = req_cmp[g*DW +: DW];
    assign data_a[g] = req_data[g*DW +: DW];
  end

  atom_state_e   state_q;
  atom_op_e      op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cmp_q, data_q;
  logic [IW-1:0] id_q;

  logic [NUM_REQ-1:0] grant;
  logic [IW-1:0]      grant_idx;
  logic               any_req;
  logic               accept;

  assign accept = (state_q == ST_IDLE) && any_req;

  atomic_rr_arbiter #(.N(NUM_REQ)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_valid),
    .advance  (accept),
    .grant    (grant),
    .grant_idx(grant_idx),
    .any      (any_req)
  );

  assign req_ready = (state_q == ST_IDLE) ? grant : '0;

  // events brought out for the checker
  logic exec_fire, busy, exec_write_any, exec_cas_miss;
  logic ex_we_lo, ex_we_hi, ex_success, ex_error;
  logic [WORD_W-1:0] ex_wd_lo, ex_wd_hi, cur_lo, cur_hi;
  logic [DW-1:0]     ex_old;
  logic [AW-1:0]     addr_hi;

  assign exec_fire      = (state_q == ST_EXEC);
  assign busy           = (state_q != ST_IDLE);
  assign addr_hi        = addr_q | AW'(1);
  assign exec_write_any = exec_fire && (ex_we_lo || ex_we_hi);
  assign exec_cas_miss  = exec_fire && (op_q == OP_CAS || op_q == OP_DCAS)
                          && !ex_success && !ex_error;

  atomic_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_lo(addr_q),
    .addr_hi(addr_hi),
    .rd_lo  (cur_lo),
    .rd_hi  (cur_hi),
    .we_lo  (exec_fire && ex_we_lo),
    .wd_lo  (ex_wd_lo),
    .we_hi  (exec_fire && ex_we_hi),
    .wd_hi  (ex_wd_hi)
  );

  atomic_exec_core #(.WORD_W(WORD_W), .AW(AW)) u_core (
    .op     (op_q),
    .addr   (addr_q),
    .cmp    (cmp_q),
    .data   (data_q),
    .cur_lo (cur_lo),
    .cur_hi (cur_hi),
    .we_lo  (ex_we_lo),
    .we_hi  (ex_we_hi),
    .wd_lo  (ex_wd_lo),
    .wd_hi  (ex_wd_hi),
    .old    (ex_old),
    .success(ex_success),
    .error  (ex_error)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_CAS;
      addr_q      <= '0;
      cmp_q       <= '0;
      data_q      <= '0;
      id_q        <= '0;
      rsp_old     <= '0;
      rsp_success <= 1'b0;
      rsp_error   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= atom_op_e'(op_a[grant_idx]);
          addr_q  <= addr_a[grant_idx];
          cmp_q   <= cmp_a[grant_idx];
          data_q  <= data_a[grant_idx];
          id_q    <= grant_idx;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          rsp_old     <= ex_old;
          rsp_success <= ex_success;
          rsp_error   <= ex_error;
          state_q     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_id    = id_q;
endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk #(
  parameter int WORD_W  = 64,
  parameter int NUM_REQ = 2,
  parameter int IW      = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_REQ-1:0]   req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [IW-1:0]        rsp_id,
  input logic [2*WORD_W-1:0]  rsp_old,
  input logic                 rsp_success,
  input logic                 rsp_error,
  input logic                 busy,
  input logic                 exec_fire,
  input logic                 exec_write_any,
  input logic                 exec_error,
  input logic                 exec_cas_miss
);
  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R7
  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req_ready == '0)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old) && $stable(rsp_id)
      && $stable(rsp_success) && $stable(rsp_error))); // R9
  AST_EXEC_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> rsp_valid); // R9
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && exec_error) |-> !exec_write_any); // R5
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_cas_miss |-> !exec_write_any); // R2
  AST_ERR_NOT_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_error && rsp_success)); // R6
endmodule

bind atomic_rmw_unit atomic_rmw_chk #(.WORD_W(WORD_W), .NUM_REQ(NUM_REQ), .IW(IW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_id        (rsp_id),
  .rsp_old       (rsp_old),
  .rsp_success   (rsp_success),
  .rsp_error     (rsp_error),
  .busy          (busy),
  .exec_fire     (exec_fire),
  .exec_write_any(exec_write_any),
  .exec_error    (ex_error),
  .exec_cas_miss (exec_cas_miss)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;
  localparam int W  = 64;
  localparam int D  = 16;
  localparam int N  = 2;
  localparam int AW = 4;
  localparam int IW = 1;
  localparam int DW = 2 * W;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0]      req_valid = '0;
  logic [N-1:0]      req_ready;
  logic [2*N-1:0]    req_op = '0;
  logic [AW*N-1:0]   req_addr = '0;
  logic [DW*N-1:0]   req_cmp = '0;
  logic [DW*N-1:0]   req_data = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1;
  logic [IW-1:0]     rsp_id;
  logic [DW-1:0]     rsp_old;
  logic              rsp_success, rsp_error;

  always #2 clk = ~clk;

  atomic_rmw_unit #(.WORD_W(W), .DEPTH(D), .NUM_REQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_cmp(req_cmp), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_old(rsp_old),
    .rsp_success(rsp_success), .rsp_error(rsp_error)
  );

  typedef struct {
    int          id;
    logic [DW-1:0] old;
    logic        succ;
    logic        err;
    string       tag;
  } exp_t;

  exp_t          sb[$];
  logic [W-1:0]  mdl [D];
  int            checks = 0, fails = 0;
  int            last_grant = N - 1;
  bit            stall_on = 0;
  bit            done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference computation, written from the requirements
  task automatic predict(input int idx, input int op, input int a,
                         input logic [DW-1:0] c, input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.id = idx; e.old = '0; e.succ = 0; e.err = 0; e.tag = tag;
    if (op == 0) begin
      e.old = {{W{1'b0}}, mdl[a]};
      if (mdl[a] == c[W-1:0]) begin mdl[a] = d[W-1:0]; e.succ = 1; end
    end else if (op == 1) begin
      e.old = {{W{1'b0}}, mdl[a]};
      mdl[a] = mdl[a] + d[W-1:0];
    end else if (op == 2) begin
      if (a % 2 == 1) e.err = 1;
      else begin
        e.old = {mdl[a+1], mdl[a]};
        if (e.old == c) begin mdl[a] = d[W-1:0]; mdl[a+1] = d[DW-1:W]; e.succ = 1; end
      end
    end else e.err = 1;
    sb.push_back(e);
  endtask

  task automatic load(input int idx, input int op, input int a,
                      input logic [DW-1:0] c, input logic [DW-1:0] d);
    req_op[idx*2 +: 2]     = 2'(op);
    req_addr[idx*AW +: AW] = AW'(a);
    req_cmp[idx*DW +: DW]  = c;
    req_data[idx*DW +: DW] = d;
    req_valid[idx]         = 1'b1;
  endtask

  task automatic issue(input int idx, input int op, input int a,
                       input logic [DW-1:0] c, input logic [DW-1:0] d, input string tag);
    load(idx, op, a, c, d);
    do @(negedge clk); while (!req_ready[idx]);
    @(posedge clk); #1;
    req_valid[idx] = 1'b0;
    last_grant = idx;
    predict(idx, op, a, c, d, tag);
  endtask

  // both requesters valid together; winner predicted from the last grant (R8)
  task automatic contend(input int a0, input logic [W-1:0] d0,
                         input int a1, input logic [W-1:0] d1);
    int win, lose;
    load(0, 1, a0, '0, {{W{1'b0}}, d0});
    load(1, 1, a1, '0, {{W{1'b0}}, d1});
    win = (last_grant + 1) % N;
    lose = 1 - win;
    do @(negedge clk); while (req_ready == '0);
    check(req_ready[win] && !req_ready[lose], "R8", "contested grant",
          DW'(req_ready), DW'(1 << win));
    @(posedge clk); #1;
    req_valid[win] = 1'b0;
    last_grant = win;
    predict(win, 1, win == 0 ? a0 : a1, '0, {{W{1'b0}}, win == 0 ? d0 : d1}, "R8");
    do @(negedge clk); while (!req_ready[lose]);
    @(posedge clk); #1;
    req_valid[lose] = 1'b0;
    last_grant = lose;
    predict(lose, 1, lose == 0 ? a0 : a1, '0, {{W{1'b0}}, lose == 0 ? d0 : d1}, "R8");
  endtask

  // response back-pressure pattern
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      cnt++;
      rsp_ready = stall_on ? (cnt % 3 == 0) : 1'b1;
    end
  end

  // monitor: compares responses against the scoreboard
  initial begin
    bit            held = 0;
    logic [DW-1:0] h_old;
    logic          h_s, h_e;
    logic [IW-1:0] h_id;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held) begin
          check(rsp_valid && rsp_old == h_old && rsp_id == h_id && rsp_success == h_s
                && rsp_error == h_e, "R9", "held response changed", rsp_old, h_old);
        end
        if (rsp_valid) begin
          check(req_ready == '0, "R7", "ready during response", DW'(req_ready), '0);
        end
        held = rsp_valid && !rsp_ready;
        h_old = rsp_old; h_id = rsp_id; h_s = rsp_success; h_e = rsp_error;
        if (rsp_valid && rsp_ready) begin
          if (sb.size() == 0) begin
            check(0, "R9", "unexpected response", rsp_old, '0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(int'(rsp_id) == e.id, "R9", "response id", DW'(rsp_id), DW'(e.id));
            check(rsp_old == e.old, e.tag, "old value", rsp_old, e.old);
            check(rsp_success == e.succ, e.tag, "success", DW'(rsp_success), DW'(e.succ));
            check(rsp_error == e.err, e.tag, "error", DW'(rsp_error), DW'(e.err));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired, actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) mdl[i] = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check(!rsp_valid, "R10", "response valid after reset", DW'(rsp_valid), '0);
    @(posedge clk); #1;

    issue(0, 1, 3, '0, '0, "R10");
    issue(1, 1, 15, '0, '0, "R10");
    issue(0, 0, 3, '0, DW'(64'h1111_2222_3333_4444), "R1");
    issue(1, 0, 3, '0, DW'(64'h5), "R2");
    issue(0, 1, 3, '0, '0, "R2");
    issue(0, 1, 5, '0, DW'({W{1'b1}}), "R3");
    issue(1, 1, 5, '0, DW'(64'h2), "R3");
    issue(0, 1, 5, '0, '0, "R3");
    issue(0, 2, 8, '0, {64'hAAAA_0000_0000_BBBB, 64'hCCCC_0000_0000_DDDD}, "R4");
    issue(1, 2, 8, {64'hAAAA_0000_0000_BBB0, 64'hCCCC_0000_0000_DDDD}, '0, "R4");
    issue(0, 1, 8, '0, '0, "R4");
    issue(0, 1, 9, '0, '0, "R4");
    issue(1, 2, 8, {64'hAAAA_0000_0000_BBBB, 64'hCCCC_0000_0000_DDDD},
          {64'h1, 64'h2}, "R4");
    issue(1, 2, 9, {64'h0, 64'h1}, {64'h7, 64'h7}, "R5");
    issue(0, 1, 9, '0, '0, "R5");
    issue(0, 1, 10, '0, '0, "R5");
    issue(1, 3, 3, DW'(64'h1111_2222_3333_4444), '0, "R6");
    issue(0, 1, 3, '0, '0, "R6");

    stall_on = 1;
    for (int k = 0; k < 4; k++) contend(12, W'(k + 1), 12, W'(16 * (k + 1)));
    issue(1, 1, 12, '0, '0, "R8");
    contend(4, 64'h10, 6, 64'h20);
    issue(0, 0, 4, DW'(64'h10), DW'(64'h99), "R1");
    stall_on = 0;
    contend(13, 64'h3, 14, 64'h4);
    issue(0, 1, 13, '0, '0, "R3");

    while (sb.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule